// File: doc/BRIEF.md
# Two-Level Page Frame Walker

This block turns a 32-bit virtual address into a 44-bit physical address by reading two levels of translation tables from memory. A client hands it a virtual address over a valid/ready handshake. The block then reads one word from the top-level directory and one word from the second-level table. It returns the physical address and holds it until the client takes it.

Each table fills one 4096-byte page and holds 1024 entries of 4 bytes. Every entry is a 32-bit page frame number and nothing else. Because no entry can mark itself absent, every walk ends in a translation. The next-level address is built by shifting the frame number left by 12 bits and appending an offset. A root register names the frame of the directory. Software can load this register only while the walker is idle.

Only one walk runs at a time. The memory side is a single read port. It has a request handshake and a separate response strobe, and the response may take any number of cycles.

Top module: `frame_walker`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `req_ready` is 1, `mem_rd_valid` is 0 and `resp_valid` is 0.
- R2: A request is taken in a cycle where `req_valid` and `req_ready` are both 1. From the next cycle `req_ready` stays 0 until the cycle after `resp_valid` and `resp_ready` are both 1. After that cycle `req_ready` is 1 again.
- R3: The first read of a walk goes to address {root frame (32 bits), va[31:22], 2'b00}, which is 44 bits.
- R4: The second read of a walk goes to address {directory word (32 bits), va[21:12], 2'b00}.
- R5: The returned address is {table word (32 bits), va[11:0]}, so the low 12 bits of the virtual address pass through unchanged.
- R6: A walk issues exactly two reads. Each read request keeps `mem_rd_valid` high and `mem_rd_addr` stable until `mem_rd_ready` is seen. The response may arrive any number of cycles after the cycle of that handshake, but not in the same cycle.
- R7: While `resp_valid` is 1 and `resp_ready` is 0, `resp_valid` stays 1 and `resp_pa` stays stable.
- R8: Setting `root_we` while the walker is idle loads `root_frame`. A load in the same cycle as a request acceptance applies to that walk. Setting `root_we` while a walk is in progress has no effect on this walk or on later walks.
- R9: Every accepted request ends with `resp_valid`; no walk faults or stalls once memory answers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_we | input | 1 | Load enable for the root frame register, honoured only when idle |
| root_frame | input | 32 | Frame number of the top-level directory |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker can accept a request |
| req_va | input | 32 | Virtual address to translate |
| resp_valid | output | 1 | Physical address available |
| resp_ready | input | 1 | Client takes the physical address |
| resp_pa | output | 44 | Translated physical address |
| mem_rd_valid | output | 1 | Memory read request present |
| mem_rd_ready | input | 1 | Memory accepts the read request |
| mem_rd_addr | output | 44 | Byte address of the 4-byte entry to read |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 32 | Read data (one table entry) |

## Verification
- **Acceptance:** after the edge that takes a request, `req_ready` drops in the next cycle, and the directory read request appears in that same cycle.
- **Second read:** the table read request appears in the cycle after the directory word is taken.
- **Response:** `resp_valid` rises in the cycle after the table word is taken. `req_ready` returns in the cycle after the response handshake.
- **Bench timing:** the bench drives and samples only on falling edges, so every value it compares has settled since the previous rising edge. Its memory model records each accepted read address and answers at least one cycle later. This lets the bench check the two addresses and the final result against the values it predicts from the requirements, whatever stall and latency pattern is used.

// File: rtl/fw_pkg.sv
package fw_pkg;

  // Walk phases; the order is the order a walk passes through them.
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DIR  = 2'd1,
    ST_TBL  = 2'd2,
    ST_RESP = 2'd3
  } walk_state_t;

endpackage

// File: rtl/fw_ctrl.sv
module fw_ctrl
  import fw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic resp_ready,
  input  logic mem_rd_ready,
  input  logic mem_rsp_valid,
  output logic req_ready,
  output logic mem_rd_valid,
  output logic resp_valid,
  output logic idle,
  output logic ld_va,
  output logic ld_dir,
  output logic ld_pte,
  output logic sel_tbl
);

  walk_state_t state_q, state_d;
  logic        issued_q, issued_d;

  // Named events, used by the next-state logic and by the assertions.
  logic req_fire;
  logic mem_fire;
  logic rsp_take;
  logic resp_fire;
  logic in_read;

  always_comb begin
    idle         = (state_q == ST_IDLE);
    in_read      = (state_q == ST_DIR) || (state_q == ST_TBL);
    req_ready    = idle;
    mem_rd_valid = in_read && !issued_q;
    resp_valid   = (state_q == ST_RESP);
    req_fire     = req_valid && req_ready;
    mem_fire     = mem_rd_valid && mem_rd_ready;
    rsp_take     = in_read && issued_q && mem_rsp_valid;
    resp_fire    = resp_valid && resp_ready;
    ld_va        = req_fire;
    ld_dir       = rsp_take && (state_q == ST_DIR);
    ld_pte       = rsp_take && (state_q == ST_TBL);
    sel_tbl      = (state_q == ST_TBL);
  end

  always_comb begin
    state_d  = state_q;
    issued_d = issued_q;
    unique case (state_q)
      ST_IDLE: if (req_fire) begin
        state_d  = ST_DIR;
        issued_d = 1'b0;
      end
      ST_DIR: begin
        if (mem_fire) issued_d = 1'b1;
        if (rsp_take) begin
          state_d  = ST_TBL;
          issued_d = 1'b0;
        end
      end
      ST_TBL: begin
        if (mem_fire) issued_d = 1'b1;
        if (rsp_take) begin
          state_d  = ST_RESP;
          issued_d = 1'b0;
        end
      end
      ST_RESP: if (resp_fire) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      issued_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      issued_q <= issued_d;
    end
  end

  // R2: once a request is taken the walker stops accepting new ones.
  p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |=> !req_ready);

  // R2: a taken response reopens the request side.
  p_ready_after_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    resp_fire |=> req_ready);

  // R6: a pending read request is not withdrawn.
  p_memreq_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid && !mem_rd_ready |=> mem_rd_valid);

  // R7: a pending response is not withdrawn.
  p_resp_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_ready |=> resp_valid);

  // R9: the table word always leads to a response in the next cycle.
  p_table_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ld_pte |=> resp_valid);

endmodule

// File: rtl/fw_datapath.sv
module fw_datapath #(
  parameter int VA_W    = 32,
  parameter int PA_W    = 44,
  parameter int PG_BITS = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                idle,
  input  logic                ld_va,
  input  logic                ld_root,
  input  logic                ld_dir,
  input  logic                ld_pte,
  input  logic                sel_tbl,
  input  logic [VA_W-1:0]     req_va,
  input  logic [PA_W-PG_BITS-1:0] root_in,
  input  logic [PA_W-PG_BITS-1:0] mem_rsp_data,
  output logic [PA_W-1:0]     mem_rd_addr,
  output logic [PA_W-1:0]     resp_pa
);

  localparam int ENT_W   = PA_W - PG_BITS;            // frame number width
  localparam int IDX_W   = (VA_W - PG_BITS) / 2;      // index bits per level
  localparam int ESZ_LOG = PA_W - ENT_W - IDX_W;      // log2 of entry bytes
  localparam int DIR_LSB = PG_BITS + IDX_W;
  localparam int TBL_LSB = PG_BITS;

  // Entry address inside a table: frame shifted up by a page, plus index
  // scaled by the entry size.
  function automatic logic [PA_W-1:0] entry_addr(
    input logic [ENT_W-1:0] base_frame,
    input logic [IDX_W-1:0] idx
  );
    return {base_frame, idx, {ESZ_LOG{1'b0}}};
  endfunction

  // Final address: frame shifted up by a page, plus untranslated offset.
  function automatic logic [PA_W-1:0] join_pa(
    input logic [ENT_W-1:0]   frame,
    input logic [PG_BITS-1:0] off
  );
    return {frame, off};
  endfunction

  logic [VA_W-1:0]  va_q;
  logic [ENT_W-1:0] root_q;
  logic [ENT_W-1:0] dir_q;
  logic [ENT_W-1:0] pte_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      va_q   <= '0;
      root_q <= '0;
      dir_q  <= '0;
      pte_q  <= '0;
    end else begin
      if (ld_va)   va_q   <= req_va;
      if (ld_root) root_q <= root_in;
      if (ld_dir)  dir_q  <= mem_rsp_data;
      if (ld_pte)  pte_q  <= mem_rsp_data;
    end
  end

  logic [IDX_W-1:0] dir_idx;
  logic [IDX_W-1:0] tbl_idx;
  logic [PA_W-1:0]  lvl_addr [2];

  assign dir_idx = va_q[DIR_LSB +: IDX_W];
  assign tbl_idx = va_q[TBL_LSB +: IDX_W];

  // One address former per table level.
  for (genvar lv = 0; lv < 2; lv++) begin : g_level
    if (lv == 0) begin : g_dir
      assign lvl_addr[lv] = entry_addr(root_q, dir_idx);
    end else begin : g_tbl
      assign lvl_addr[lv] = entry_addr(dir_q, tbl_idx);
    end
  end

  assign mem_rd_addr = sel_tbl ? lvl_addr[1] : lvl_addr[0];
  assign resp_pa     = join_pa(pte_q, va_q[PG_BITS-1:0]);

  // R8: the root frame is frozen while a walk is in progress.
  p_root_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |=> $stable(root_q));

  // R5: the virtual address is held for the whole walk.
  p_va_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |=> $stable(va_q));

endmodule

// File: rtl/frame_walker.sv
module frame_walker #(
  parameter int VA_W    = 32,
  parameter int PA_W    = 44,
  parameter int PG_BITS = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    root_we,
  input  logic [PA_W-PG_BITS-1:0] root_frame,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [VA_W-1:0]         req_va,
  output logic                    resp_valid,
  input  logic                    resp_ready,
  output logic [PA_W-1:0]         resp_pa,
  output logic                    mem_rd_valid,
  input  logic                    mem_rd_ready,
  output logic [PA_W-1:0]         mem_rd_addr,
  input  logic                    mem_rsp_valid,
  input  logic [PA_W-PG_BITS-1:0] mem_rsp_data
);

  logic idle;
  logic ld_va;
  logic ld_dir;
  logic ld_pte;
  logic sel_tbl;
  logic ld_root;

  assign ld_root = root_we && idle;

  fw_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .resp_ready   (resp_ready),
    .mem_rd_ready (mem_rd_ready),
    .mem_rsp_valid(mem_rsp_valid),
    .req_ready    (req_ready),
    .mem_rd_valid (mem_rd_valid),
    .resp_valid   (resp_valid),
    .idle         (idle),
    .ld_va        (ld_va),
    .ld_dir       (ld_dir),
    .ld_pte       (ld_pte),
    .sel_tbl      (sel_tbl)
  );

  fw_datapath #(
    .VA_W   (VA_W),
    .PA_W   (PA_W),
    .PG_BITS(PG_BITS)
  ) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .idle        (idle),
    .ld_va       (ld_va),
    .ld_root     (ld_root),
    .ld_dir      (ld_dir),
    .ld_pte      (ld_pte),
    .sel_tbl     (sel_tbl),
    .req_va      (req_va),
    .root_in     (root_frame),
    .mem_rsp_data(mem_rsp_data),
    .mem_rd_addr (mem_rd_addr),
    .resp_pa     (resp_pa)
  );

  // R6: the read address does not move while the request waits.
  p_memaddr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid && !mem_rd_ready |=> $stable(mem_rd_addr));

  // R7: the result does not move while the client stalls.
  p_pa_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_ready |=> $stable(resp_pa));

  // R2: memory is never asked for data while a result is on offer or idle.
  p_one_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_ready, mem_rd_valid, resp_valid}));

endmodule

// File: tb/frame_walker_bench.sv
`timescale 1ns/1ps
module frame_walker_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        root_we;
  logic [31:0] root_frame;
  logic        req_valid;
  logic        req_ready;
  logic [31:0] req_va;
  logic        resp_valid;
  logic        resp_ready;
  logic [43:0] resp_pa;
  logic        mem_rd_valid;
  logic        mem_rd_ready;
  logic [43:0] mem_rd_addr;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;

  always #4 clk = ~clk;  // 125 MHz

  frame_walker u_frame_walker (
    .clk          (clk),
    .rst_n        (rst_n),
    .root_we      (root_we),
    .root_frame   (root_frame),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_va       (req_va),
    .resp_valid   (resp_valid),
    .resp_ready   (resp_ready),
    .resp_pa      (resp_pa),
    .mem_rd_valid (mem_rd_valid),
    .mem_rd_ready (mem_rd_ready),
    .mem_rd_addr  (mem_rd_addr),
    .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data (mem_rsp_data)
  );

  int          checks = 0;
  int          errors = 0;
  logic [31:0] root_model;
  logic [43:0] log_addr [2];
  int          log_n;
  int          wait_cnt;
  logic [15:0] lf;

  // Memory contents: a fixed mix of the word address.
  function automatic logic [31:0] mem_word(input logic [43:0] a);
    logic [31:0] lo;
    lo = a[33:2];
    return (lo * 32'h9E37_79B1) ^ {a[43:34], 22'h2A5A5};
  endfunction

  function automatic logic [15:0] lfsr_step(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  task automatic chk(input bit ok, input string tag,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Memory model: random stall on request, random latency 1..4 cycles.
  initial begin
    mem_rd_ready  = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    wait_cnt      = 0;
    lf            = 16'hACE1;
    log_n         = 0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      mem_rd_ready  = 1'b0;
      if (wait_cnt > 0) begin
        wait_cnt--;
        if (wait_cnt == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = mem_word(log_addr[(log_n - 1) & 1]);
        end
      end else if (rst_n && mem_rd_valid) begin
        lf = lfsr_step(lf);
        if (lf[0] | lf[3]) begin
          mem_rd_ready = 1'b1;
          if (log_n < 2) log_addr[log_n] = mem_rd_addr;
          log_n++;
          wait_cnt = 1 + int'(lf[5:4]);
        end
      end
    end
  end

  task automatic load_root(input logic [31:0] r);
    @(negedge clk);
    root_we    = 1'b1;
    root_frame = r;
    root_model = r;
    @(negedge clk);
    root_we    = 1'b0;
  endtask

  task automatic walk(input logic [31:0] va, input int hold,
                      input bit poke, input bit load_now, input logic [31:0] nr);
    logic [43:0] da, ta, pa, pa0;
    logic [31:0] de, pte;
    int n;
    @(negedge clk);
    if (load_now) begin
      root_we    = 1'b1;
      root_frame = nr;
      root_model = nr;
    end
    da  = {root_model, va[31:22], 2'b00};
    de  = mem_word(da);
    ta  = {de, va[21:12], 2'b00};
    pte = mem_word(ta);
    pa  = {pte, va[11:0]};
    log_n     = 0;
    req_va    = va;
    req_valid = 1'b1;
    chk(req_ready == 1'b1, "R2 ready when idle", 64'(req_ready), 64'd1);
    @(negedge clk);
    req_valid = 1'b0;
    root_we   = 1'b0;
    chk(req_ready == 1'b0, "R2 busy after accept", 64'(req_ready), 64'd0);
    if (poke) begin
      // R8: a load attempt mid-walk must be ignored.
      root_we    = 1'b1;
      root_frame = ~root_model;
      @(negedge clk);
      root_we    = 1'b0;
    end
    n = 0;
    while (!resp_valid && n < 400) begin
      @(negedge clk);
      chk(req_ready == 1'b0 || resp_valid, "R2 busy during walk", 64'(req_ready), 64'd0);
      n++;
    end
    chk(resp_valid == 1'b1, "R9 walk completes", 64'(resp_valid), 64'd1);
    pa0 = resp_pa;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk(resp_valid && resp_pa == pa0, "R7 result held", 64'(resp_pa), 64'(pa0));
    end
    chk(resp_pa == pa, "R5 physical address", 64'(resp_pa), 64'(pa));
    chk(log_n == 2, "R6 two reads per walk", 64'(log_n), 64'd2);
    chk(log_addr[0] == da, "R3 directory address", 64'(log_addr[0]), 64'(da));
    chk(log_addr[1] == ta, "R4 table address", 64'(log_addr[1]), 64'(ta));
    resp_ready = 1'b1;
    @(negedge clk);
    resp_ready = 1'b0;
    chk(!resp_valid && req_ready, "R2 ready after response",
        64'({resp_valid, req_ready}), 64'b01);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] va;
    rst_n      = 1'b0;
    root_we    = 1'b0;
    root_frame = '0;
    req_valid  = 1'b0;
    req_va     = '0;
    resp_ready = 1'b0;
    root_model = '0;
    repeat (3) @(negedge clk);
    chk(req_ready && !mem_rd_valid && !resp_valid, "R1 state in reset",
        64'({req_ready, mem_rd_valid, resp_valid}), 64'b100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !mem_rd_valid && !resp_valid, "R1 state after reset",
        64'({req_ready, mem_rd_valid, resp_valid}), 64'b100);

    // Root at reset value zero, extreme addresses.
    walk(32'h0000_0000, 0, 0, 0, '0);
    walk(32'hFFFF_FFFF, 2, 0, 0, '0);

    // R8: idle load, then mid-walk pokes must not take effect.
    load_root(32'hC0DE_1234);
    walk(32'h1234_5678, 1, 1, 0, '0);
    walk(32'h8765_4321, 0, 0, 0, '0);

    // Directory index sweep.
    for (int d = 0; d < 1024; d++) begin
      va = {d[9:0], 10'(d * 37), 12'(d * 13)};
      walk(va, d % 3, (d % 5) == 0, (d % 97) == 0, 32'(d) * 32'h0101_0F0F);
    end

    // Table index sweep under a full-ones root loaded with the request.
    walk(32'hABCD_E000, 0, 0, 1, 32'hFFFF_FFFF);
    for (int t = 0; t < 1024; t++) begin
      va = {10'h2B5, t[9:0], 12'(t * 29)};
      walk(va, t % 2, (t % 7) == 0, 0, '0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule